// File: doc/BRIEF.md
# Port Error Interrupt Status Register

This block holds the interrupt status word of one serial storage host port. Single-cycle error and event pulses from the link, transport and DMA logic land in sticky status bits. Software reads the word and clears a bit by writing a one to its position. Three positions are read-only: they copy external flags, and a software write does not clear them. Bit 28 always reads 0, and so do the reserved positions. One interrupt output is raised while any status bit that is also set in an enable vector holds a one.

Two of the conditions, interface fatal error and overflow, also halt the port DMA. A separate latch, `dma_fatal`, records that halt. Software clearing the status bits does not release it. Only a low run bit, a port reset or a global reset releases it. The register bus has no address: a write strobe with a 32-bit data word targets this register, and the current value is always presented on the read port.

Top module: `port_err_irq_status`

## Requirements
- R1: After global reset `rd_data` is 0, `irq` is 0 and `dma_fatal` is 0.
- R2: Each write-one-to-clear bit (30, 29, 27, 26, 24, 23, 7, 5, 3, 2, 1, 0) is set on the clock edge that samples its event. It holds until an edge with `wr_en`=1 and a 1 in its `wr_data` position. A 0 in that position leaves it unchanged.
- R3: When a set event and a write-one-to-clear reach the same bit on the same edge, the bit ends up set.
- R4: Bits 31, 28, 25 and 21..8 always read 0, whatever is written.
- R5: Bit 22 copies `phy_rdy_diag` and bits 6 and 4 copy `ro_flags[1]` and `ro_flags[0]`, each one edge later. Writing ones to these positions does not clear them.
- R6: Bit 30 sets only on an edge where `ev_tf_update` and `ev_tf_err` are both 1.
- R7: Bit 27 sets on any of `ev_sync_esc`, `ev_data_fis_err`, `ev_long_unk_fis` or `ev_zero_prd`.
- R8: Bit 26 sets on `ev_nondata_err` or `ev_rd_underflow`, and these events never raise `dma_fatal`.
- R9: With `run`=1 and `port_rst`=0, any bit-27 event or `ev_overflow` sets `dma_fatal` on the same edge. Clearing the status bits does not release it. An edge with `run`=0 or `port_rst`=1 clears it.
- R10: `irq` equals the OR over all bits of (status AND `irq_en`) as both stood at the previous edge. It therefore follows a status change by one edge.
- R11: Bit 29 sets on `ev_hbus_fatal`, bit 24 on `ev_overflow` and bit 23 on `ev_bad_pm`. `ev_misc[5:0]` set bits 7, 5, 3, 2, 1 and 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| port_rst | input | 1 | Port reset, releases the DMA halt |
| run | input | 1 | Port start/run control bit |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, ones clear bits |
| rd_data | output | 32 | Current status word |
| irq_en | input | 32 | Interrupt enable vector |
| irq | output | 1 | Interrupt request |
| dma_fatal | output | 1 | DMA fatal-halt state |
| ev_tf_update | input | 1 | Task-file register updated by device |
| ev_tf_err | input | 1 | Error bit of that task-file update |
| ev_hbus_fatal | input | 1 | Bus master received an error response |
| ev_sync_esc | input | 1 | SYNC escape during outbound register or data FIS |
| ev_data_fis_err | input | 1 | Link error during a data FIS |
| ev_long_unk_fis | input | 1 | Unknown FIS, good CRC, longer than 64 bytes |
| ev_zero_prd | input | 1 | PRD byte count of zero |
| ev_nondata_err | input | 1 | Link error during a non-data FIS |
| ev_rd_underflow | input | 1 | Command list underflow on a read |
| ev_overflow | input | 1 | Command list overflow |
| ev_bad_pm | input | 1 | FIS with an unexpected port-multiplier field |
| ev_misc | input | 6 | Events for the low-order write-one-to-clear bits |
| phy_rdy_diag | input | 1 | PHY-ready change diagnostic flag |
| ro_flags | input | 2 | Flags copied to read-only bits 6 and 4 |

## Verification
Every status bit and `dma_fatal` is due on the edge that samples its event, write or control input. `irq` is due one edge after that. The bench changes inputs on the falling edge, lets exactly one rising edge pass and compares at the next falling edge. For `irq` it compares against the expected status of the step before, or it lets a second edge pass. The checks of the read-only copies, of the DMA halt latch and of the enable mask all use the same one-edge timing.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int REG_W  = 32;
  localparam int N_MISC = 6;

  localparam int B_TFE  = 30;
  localparam int B_HBF  = 29;
  localparam int B_IFE  = 27;
  localparam int B_INF  = 26;
  localparam int B_OVF  = 24;
  localparam int B_IPM  = 23;
  localparam int B_PRC  = 22;
  localparam int B_RO_HI = 6;
  localparam int B_RO_LO = 4;

  localparam logic [REG_W-1:0] W1C_MASK = 32'h6D80_00AF;
  localparam logic [REG_W-1:0] RO_MASK  = 32'h0040_0050;

  // position of misc event k inside the status word
  function automatic int misc_pos(input int k);
    case (k)
      5: misc_pos = 7;
      4: misc_pos = 5;
      3: misc_pos = 3;
      2: misc_pos = 2;
      1: misc_pos = 1;
      default: misc_pos = 0;
    endcase
  endfunction
endpackage

// File: rtl/pis_event_map.sv
module pis_event_map
  import pis_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NM = N_MISC
) (
  input  logic          ev_tf_update,
  input  logic          ev_tf_err,
  input  logic          ev_hbus_fatal,
  input  logic          ev_sync_esc,
  input  logic          ev_data_fis_err,
  input  logic          ev_long_unk_fis,
  input  logic          ev_zero_prd,
  input  logic          ev_nondata_err,
  input  logic          ev_rd_underflow,
  input  logic          ev_overflow,
  input  logic          ev_bad_pm,
  input  logic [NM-1:0] ev_misc,
  output logic [W-1:0]  set_vec,
  output logic          fatal_trig
);
  logic [W-1:0] misc_vec;
  logic         if_fatal;

  assign if_fatal = ev_sync_esc | ev_data_fis_err | ev_long_unk_fis | ev_zero_prd;

  always_comb begin
    misc_vec = '0;
    for (int k = 0; k < NM; k++) misc_vec[misc_pos(k)] = ev_misc[k];
  end

  always_comb begin
    set_vec        = misc_vec;
    set_vec[B_TFE] = ev_tf_update & ev_tf_err;
    set_vec[B_HBF] = ev_hbus_fatal;
    set_vec[B_IFE] = if_fatal;
    set_vec[B_INF] = ev_nondata_err | ev_rd_underflow;
    set_vec[B_OVF] = ev_overflow;
    set_vec[B_IPM] = ev_bad_pm;
  end

  assign fatal_trig = if_fatal | ev_overflow;
endmodule

// File: rtl/pis_w1c_bank.sv
module pis_w1c_bank #(
  parameter int          W        = 32,
  parameter logic [W-1:0] CLR_MASK = '0,
  parameter logic [W-1:0] CPY_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] mirror_vec,
  output logic [W-1:0] q
);
  logic unused_bank;
  assign unused_bank = ^{set_vec & ~CLR_MASK, wr_data & ~CLR_MASK, mirror_vec & ~CPY_MASK};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (CLR_MASK[i]) begin : g_w1c
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= set_vec[i] | (q[i] & ~(wr_en & wr_data[i]));
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> q[i]);                                        // R3
      AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[i] && !set_vec[i]) |=> !q[i]);             // R2
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!set_vec[i] && !(wr_en && wr_data[i])) |=> $stable(q[i]));  // R2
    end else if (CPY_MASK[i]) begin : g_copy
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= mirror_vec[i];
      end

      AST_MIRROR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q[i] == $past(mirror_vec[i])));                    // R5
    end else begin : g_zero
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pis_fatal_latch.sv
module pis_fatal_latch (
  input  logic clk,
  input  logic rst,
  input  logic port_rst,
  input  logic run,
  input  logic trig,
  output logic fatal
);
  always_ff @(posedge clk) begin
    if (rst || port_rst || !run) fatal <= 1'b0;
    else if (trig)               fatal <= 1'b1;
  end

  AST_FATAL_SET: assert property (@(posedge clk) disable iff (rst)
    (run && !port_rst && trig) |=> fatal);                  // R9
  AST_FATAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!run || port_rst) |=> !fatal);                         // R9
  AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && !port_rst && !trig) |=> $stable(fatal));        // R9
endmodule

// File: rtl/port_err_irq_status.sv
module port_err_irq_status
  import pis_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              port_rst,
  input  logic              run,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [REG_W-1:0]  irq_en,
  output logic              irq,
  output logic              dma_fatal,
  input  logic              ev_tf_update,
  input  logic              ev_tf_err,
  input  logic              ev_hbus_fatal,
  input  logic              ev_sync_esc,
  input  logic              ev_data_fis_err,
  input  logic              ev_long_unk_fis,
  input  logic              ev_zero_prd,
  input  logic              ev_nondata_err,
  input  logic              ev_rd_underflow,
  input  logic              ev_overflow,
  input  logic              ev_bad_pm,
  input  logic [N_MISC-1:0] ev_misc,
  input  logic              phy_rdy_diag,
  input  logic [1:0]        ro_flags
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] mirror_vec;
  logic [REG_W-1:0] status_q;
  logic             fatal_trig;
  logic             irq_q;

  pis_event_map #(.W(REG_W), .NM(N_MISC)) u_map (
    .ev_tf_update    (ev_tf_update),
    .ev_tf_err       (ev_tf_err),
    .ev_hbus_fatal   (ev_hbus_fatal),
    .ev_sync_esc     (ev_sync_esc),
    .ev_data_fis_err (ev_data_fis_err),
    .ev_long_unk_fis (ev_long_unk_fis),
    .ev_zero_prd     (ev_zero_prd),
    .ev_nondata_err  (ev_nondata_err),
    .ev_rd_underflow (ev_rd_underflow),
    .ev_overflow     (ev_overflow),
    .ev_bad_pm       (ev_bad_pm),
    .ev_misc         (ev_misc),
    .set_vec         (set_vec),
    .fatal_trig      (fatal_trig)
  );

  always_comb begin
    mirror_vec          = '0;
    mirror_vec[B_PRC]   = phy_rdy_diag;
    mirror_vec[B_RO_HI] = ro_flags[1];
    mirror_vec[B_RO_LO] = ro_flags[0];
  end

  pis_w1c_bank #(.W(REG_W), .CLR_MASK(W1C_MASK), .CPY_MASK(RO_MASK)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_vec    (set_vec),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .mirror_vec (mirror_vec),
    .q          (status_q)
  );

  pis_fatal_latch u_fatal (
    .clk      (clk),
    .rst      (rst),
    .port_rst (port_rst),
    .run      (run),
    .trig     (fatal_trig),
    .fatal    (dma_fatal)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_q & irq_en);
  end

  assign irq     = irq_q;
  assign rd_data = status_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~(W1C_MASK | RO_MASK)) == '0);                       // R4
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(rd_data) & $past(irq_en))));          // R10
  AST_NONFATAL_NO_HALT: assert property (@(posedge clk) disable iff (rst)
    (!dma_fatal && !ev_sync_esc && !ev_data_fis_err && !ev_long_unk_fis
     && !ev_zero_prd && !ev_overflow) |=> !dma_fatal);              // R8
endmodule

// File: tb/port_err_irq_status_bench.sv
`timescale 1ns/1ps
module port_err_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst, port_rst, run, wr_en;
  logic [31:0] wr_data, rd_data, irq_en;
  logic        irq, dma_fatal;
  logic        ev_tf_update, ev_tf_err, ev_hbus_fatal, ev_sync_esc, ev_data_fis_err;
  logic        ev_long_unk_fis, ev_zero_prd, ev_nondata_err, ev_rd_underflow;
  logic        ev_overflow, ev_bad_pm;
  logic [5:0]  ev_misc;
  logic        phy_rdy_diag;
  logic [1:0]  ro_flags;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  port_err_irq_status u_port_err_irq_status (
    .clk(clk), .rst(rst), .port_rst(port_rst), .run(run), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_en(irq_en), .irq(irq),
    .dma_fatal(dma_fatal), .ev_tf_update(ev_tf_update), .ev_tf_err(ev_tf_err),
    .ev_hbus_fatal(ev_hbus_fatal), .ev_sync_esc(ev_sync_esc),
    .ev_data_fis_err(ev_data_fis_err), .ev_long_unk_fis(ev_long_unk_fis),
    .ev_zero_prd(ev_zero_prd), .ev_nondata_err(ev_nondata_err),
    .ev_rd_underflow(ev_rd_underflow), .ev_overflow(ev_overflow),
    .ev_bad_pm(ev_bad_pm), .ev_misc(ev_misc), .phy_rdy_diag(phy_rdy_diag),
    .ro_flags(ro_flags)
  );

  // event word: [10]bad_pm [9]overflow [8]rd_underflow [7]nondata [6]zero_prd
  // [5]long_unk [4]data_fis [3]sync_esc [2]hbus_fatal [1]tf_err [0]tf_update
  // entry: {ev[10:0], misc[5:0], wr_en, wr_data[31:0], expected status[31:0]}
  localparam int NV = 21;
  localparam logic [81:0] TBL [NV] = '{
    {11'h001, 6'h00, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R6 update alone
    {11'h002, 6'h00, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R6 err alone
    {11'h003, 6'h00, 1'b0, 32'h0000_0000, 32'h4000_0000}, // R6 both
    {11'h000, 6'h00, 1'b1, 32'h0000_0000, 32'h4000_0000}, // R2 write 0
    {11'h000, 6'h00, 1'b1, 32'h4000_0000, 32'h0000_0000}, // R2 w1c
    {11'h004, 6'h00, 1'b0, 32'h0000_0000, 32'h2000_0000}, // R11 hbus
    {11'h008, 6'h00, 1'b0, 32'h0000_0000, 32'h2800_0000}, // R7 sync esc
    {11'h000, 6'h00, 1'b1, 32'h0800_0000, 32'h2000_0000}, // R2
    {11'h010, 6'h00, 1'b1, 32'h0800_0000, 32'h2800_0000}, // R3 set wins, R7
    {11'h000, 6'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}, // R4 all ones
    {11'h020, 6'h00, 1'b0, 32'h0000_0000, 32'h0800_0000}, // R7 long unknown
    {11'h000, 6'h00, 1'b1, 32'h0800_0000, 32'h0000_0000},
    {11'h040, 6'h00, 1'b0, 32'h0000_0000, 32'h0800_0000}, // R7 zero prd
    {11'h080, 6'h00, 1'b0, 32'h0000_0000, 32'h0C00_0000}, // R8 nondata
    {11'h000, 6'h00, 1'b1, 32'h0C00_0000, 32'h0000_0000},
    {11'h100, 6'h00, 1'b0, 32'h0000_0000, 32'h0400_0000}, // R8 underflow
    {11'h200, 6'h00, 1'b0, 32'h0000_0000, 32'h0500_0000}, // R11 overflow
    {11'h400, 6'h00, 1'b0, 32'h0000_0000, 32'h0580_0000}, // R11 bad pm
    {11'h000, 6'h3F, 1'b0, 32'h0000_0000, 32'h0580_00AF}, // R11 misc
    {11'h000, 6'h00, 1'b1, 32'h0000_0025, 32'h0580_008A}, // R2 partial
    {11'h000, 6'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}  // R4
  };

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0;
    {ev_bad_pm, ev_overflow, ev_rd_underflow, ev_nondata_err, ev_zero_prd,
     ev_long_unk_fis, ev_data_fis_err, ev_sync_esc, ev_hbus_fatal, ev_tf_err,
     ev_tf_update} = '0;
    ev_misc = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] prev_exp;
    rst = 1; port_rst = 0; run = 1; irq_en = '1; phy_rdy_diag = 0; ro_flags = '0;
    idle_inputs();
    @(negedge clk); step(); step();
    // R1 reset state
    chk("R1 status", rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 fatal", {31'b0, dma_fatal}, 32'h0);
    rst = 0;
    step();

    prev_exp = '0;
    for (int v = 0; v < NV; v++) begin
      {ev_bad_pm, ev_overflow, ev_rd_underflow, ev_nondata_err, ev_zero_prd,
       ev_long_unk_fis, ev_data_fis_err, ev_sync_esc, ev_hbus_fatal, ev_tf_err,
       ev_tf_update} = TBL[v][81:71];
      ev_misc = TBL[v][70:65];
      wr_en   = TBL[v][64];
      wr_data = TBL[v][63:32];
      step();
      chk("R2/R3/R4/R6/R7/R8/R11 status", rd_data, TBL[v][31:0]);
      chk("R10 irq", {31'b0, irq}, {31'b0, |prev_exp});
      prev_exp = TBL[v][31:0];
      idle_inputs();
    end

    // release halt left by the table
    run = 0; step(); run = 1; step();
    chk("R9 released by run", {31'b0, dma_fatal}, 32'h0);

    // R5 read-only copies
    phy_rdy_diag = 1; ro_flags = 2'b11; step();
    chk("R5 copy set", rd_data, 32'h0040_0050);
    wr_en = 1; wr_data = 32'h0040_0050; step(); idle_inputs();
    chk("R5 write ignored", rd_data, 32'h0040_0050);
    phy_rdy_diag = 0; ro_flags = 2'b00; step();
    chk("R5 copy cleared", rd_data, 32'h0);
    step();

    // R9 halt latch
    ev_overflow = 1; step(); idle_inputs();
    chk("R9 set by overflow", {31'b0, dma_fatal}, 32'h1);
    wr_en = 1; wr_data = '1; step(); idle_inputs();
    chk("R9 status cleared", rd_data, 32'h0);
    chk("R9 held after clear", {31'b0, dma_fatal}, 32'h1);
    run = 0; step();
    chk("R9 run low releases", {31'b0, dma_fatal}, 32'h0);
    run = 1; ev_zero_prd = 1; step(); idle_inputs();
    chk("R9 set by zero prd", {31'b0, dma_fatal}, 32'h1);
    port_rst = 1; step(); port_rst = 0;
    chk("R9 port reset releases", {31'b0, dma_fatal}, 32'h0);
    ev_nondata_err = 1; ev_rd_underflow = 1; step(); idle_inputs();
    chk("R8 no halt", {31'b0, dma_fatal}, 32'h0);
    wr_en = 1; wr_data = '1; step(); idle_inputs(); step();

    // R10 enable mask
    irq_en = 32'hFF7F_FFFF;
    ev_bad_pm = 1; step(); idle_inputs(); step();
    chk("R10 masked", {31'b0, irq}, 32'h0);
    irq_en = 32'h0080_0000; step(); step();
    chk("R10 enabled", {31'b0, irq}, 32'h1);
    wr_en = 1; wr_data = 32'h0080_0000; step(); idle_inputs(); step();
    chk("R10 drop after clear", {31'b0, irq}, 32'h0);

    // R1 global reset clears everything again
    ev_hbus_fatal = 1; step(); idle_inputs();
    rst = 1; step(); rst = 0;
    chk("R1 reset clears", rd_data, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule